// File: doc/BRIEF.md
# Lifecycle Seed and Wipe Sequencer

This block is the top-level control sequencer of a flash lifecycle manager. After an init strobe it fetches an address scrambling key and then a data scrambling key, each through a request/acknowledge handshake. When provisioning is enabled it then reads a fixed number of secret seeds. Each seed is read twice: the first read stores it and the second read is compared against the stored copy. It then waits for a wipe request, asks for an entropy reseed, and drives a wipe engine through a series of wipe entries. When the last entry finishes it reports whether the wipe was clean.

A wipe request arrives on three separate 4-bit ports, one for each stage at which the request may take effect: before init, during key fetch, and while waiting. A request at an earlier stage pre-empts the normal sequence. A disable input parks the sequencer in a dead-end disabled state, unless the wipe has already finished. The flash read path is reduced to a done/valid/data interface. Key derivation, the wipe engine itself and data integrity checking belong to neighbouring blocks.

Top module: `seedwipe_seq`

## Requirements
- R1: After a synchronous active-low reset, every request output, `wipe_done_o`, `wipe_ok_o` and `fatal_o` is low. In the idle state an `init_i` pulse raises `addr_key_req_o` on the next cycle.
- R2: `addr_key_req_o` stays high until `addr_key_ack_i`. On the following cycle `data_key_req_o` rises and stays high until `data_key_ack_i`. After that ack, `rd_req_o` rises if `prov_en_i` is 1. Otherwise the sequencer goes to the wait state, where no request output is high.
- R3: Each wipe-request port uses a 4-bit code. 4'hA means active and 4'h5 means inactive. Any other value is treated as inactive and sets a sticky state error, which shows on `fatal_o` one cycle later.
- R4: While idle, an active `wipe_init_i` goes straight to wiping: `wipe_go_o` is high on the next cycle. While either key request is pending, an active `wipe_key_i` does the same and drops the key request.
- R5: Seeds are read in index order. `rd_seed_idx_o` gives the index, and each seed is requested twice with one evaluation cycle (request low) after each read. The first read's data, taken when `rd_valid_i` is high, goes into slot i of `seed_o` (bits i*DW and up). After 2*NSEEDS reads the sequencer enters the wait state.
- R6: If the second read of a seed differs from the stored value, a sticky seed error is set. The stored value is not changed, and the final `wipe_ok_o` is 0.
- R7: In the wait state an active `wipe_wait_i` raises `reseed_req_o` on the next cycle. `reseed_ack_i` then raises `wipe_go_o` with `wipe_idx_o` = 0.
- R8: While wiping, each `wipe_done_i` advances `wipe_idx_o` by one. A `wipe_done_i` at index NWIPE-1 ends wiping: `wipe_go_o` falls on the next cycle.
- R9: Two cycles after the final `wipe_done_i`, `wipe_done_o` goes high and stays high. `wipe_ok_o` is 1 only if no seed, state, FSM or engine error has been recorded.
- R10: `disable_i` sends the sequencer to the disabled state on the next cycle. All request outputs and `wipe_done_o` are low there, and it never leaves, even after `disable_i` is released. Once the final `wipe_done_i` has been taken, `disable_i` has no effect.
- R11: `fatal_o` is the OR of the sticky state error, the FSM error and the engine error. A `eng_err_i` pulse raises `fatal_o` on the next cycle and it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Start strobe |
| disable_i | input | 1 | Force into the disabled state |
| prov_en_i | input | 1 | Enable the seed reads |
| wipe_init_i | input | 4 | Wipe request taken while idle |
| wipe_key_i | input | 4 | Wipe request taken during key fetch |
| wipe_wait_i | input | 4 | Wipe request taken while waiting |
| addr_key_req_o | output | 1 | Address key request |
| addr_key_ack_i | input | 1 | Address key acknowledge |
| data_key_req_o | output | 1 | Data key request |
| data_key_ack_i | input | 1 | Data key acknowledge |
| rd_req_o | output | 1 | Seed read request |
| rd_seed_idx_o | output | $clog2(NSEEDS+1) | Seed index being read |
| rd_done_i | input | 1 | Read finished |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DW | Read data |
| seed_o | output | NSEEDS*DW | Stored seeds, slot i at bits i*DW and up |
| reseed_req_o | output | 1 | Entropy reseed request |
| reseed_ack_i | input | 1 | Entropy reseed acknowledge |
| wipe_go_o | output | 1 | Wipe engine run request |
| wipe_idx_o | output | $clog2(NWIPE) | Current wipe entry |
| wipe_done_i | input | 1 | Current wipe entry finished |
| eng_err_i | input | 1 | Wipe engine counter error |
| wipe_done_o | output | 1 | Wipe response present |
| wipe_ok_o | output | 1 | Wipe ended with no error |
| fatal_o | output | 1 | Sticky fatal error |

## Verification
The state is never brought out as a register, so a wrong internal state shows up as a wrong request output on the cycle after the edge that caused it. The bench therefore checks the handshake outputs one cycle after each stimulus. A seed counter or validate flag that is out of step shows as a wrong `rd_seed_idx_o`, or as a request arriving one evaluation cycle early or late, and that is seen on the next read. A lost sticky error shows only at the end, as a wrong `wipe_ok_o` two cycles after the last wipe entry. For this reason the bench completes every run through to the response.

// File: rtl/seqw_pkg.sv
// Shared types for the seed and wipe sequencer.
// Assumes: wipe requests use a 4-bit code with one active and one inactive value.
package seqw_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_ADDR_KEY, S_DATA_KEY, S_SEED_RD, S_SEED_EVAL,
        S_HOLD, S_RESEED, S_WIPE, S_WIPE_RSP, S_OFF, S_DEAD
    } seq_state_e;

    localparam int MBW = 4;
    localparam logic [MBW-1:0] MB_ON  = 4'hA;
    localparam logic [MBW-1:0] MB_OFF = 4'h5;
endpackage

// File: rtl/wipe_req_decode.sv
// Decodes the multi-bit wipe request of each stage.
// Only the exact active code counts as active. A code that is neither active nor
// inactive counts as inactive and sets a sticky error.
module wipe_req_decode
    import seqw_pkg::*;
#(
    parameter int NSTAGE = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSTAGE*MBW-1:0] req_i,
    output logic [NSTAGE-1:0]     on_o,
    output logic                  err_o
);
    logic [NSTAGE-1:0] bad;
    logic              err_q;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        // Classify one stage code.
        assign on_o[g] = (req_i[g*MBW +: MBW] == MB_ON);
        assign bad[g]  = !on_o[g] && (req_i[g*MBW +: MBW] != MB_OFF);
    end

    // Sticky record of any malformed code.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else if (|bad) err_q <= 1'b1;
    end

    assign err_o = err_q;

    // R3: a malformed code is reported on the next cycle
    a_r3_bad_code_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (|bad) |=> err_o);
    // R3: the error never clears
    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
endmodule

// File: rtl/seed_reader.sv
// Seed double-read bookkeeping: a counter, a validate flag, storage and a compare.
// Assumes read data comes with rd_valid while rd_en is high, and eval_en is high
// for exactly one cycle after each read.
module seed_reader #(
    parameter int NSEEDS = 2,
    parameter int DW     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic                 eval_en,
    input  logic                 rd_valid,
    input  logic [DW-1:0]        rd_data,
    output logic [$clog2(NSEEDS+1)-1:0] cnt_o,
    output logic                 all_done_o,
    output logic [NSEEDS*DW-1:0] seeds_o,
    output logic                 err_o
);
    localparam int CW = $clog2(NSEEDS + 1);

    logic [CW-1:0]     cnt_q;
    logic              validate_q;
    logic              err_q;
    logic [NSEEDS-1:0] miss;
    logic              take;

    assign take = rd_en && rd_valid;

    // Seed counter and pass flag, moved on in the evaluation cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            validate_q <= 1'b0;
        end else if (eval_en) begin
            validate_q <= !validate_q;
            if (validate_q) cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar g = 0; g < NSEEDS; g++) begin : g_slot
        logic [DW-1:0] slot_q;
        // Store the first-pass value of this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) slot_q <= '0;
            else if (take && !validate_q && cnt_q == CW'(g)) slot_q <= rd_data;
        end
        assign miss[g]             = take && validate_q && cnt_q == CW'(g) && slot_q != rd_data;
        assign seeds_o[g*DW +: DW] = slot_q;
    end

    // Sticky mismatch flag.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else if (|miss) err_q <= 1'b1;
    end

    assign cnt_o      = cnt_q;
    assign all_done_o = (cnt_q == CW'(NSEEDS));
    assign err_o      = err_q;

    // R5: the counter never passes the number of seeds
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(NSEEDS));
    // R6: a seed error never clears
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: rtl/wipe_index.sv
// Wipe entry index. It advances on each finished entry and flags the last entry.
// Assumes step is only high while the sequencer is wiping.
module wipe_index #(
    parameter int NWIPE = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step,
    output logic [$clog2(NWIPE)-1:0]   idx_o,
    output logic                       last_o
);
    localparam int IW = $clog2(NWIPE);

    logic [IW-1:0] idx_q;

    // Advance the index, holding at the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else if (step && !last_o) idx_q <= idx_q + 1'b1;
    end

    assign idx_o  = idx_q;
    assign last_o = (idx_q == IW'(NWIPE - 1));

    // R8: each finished non-last entry advances the index by one
    a_r8_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last_o) |=> idx_o == $past(idx_o) + 1'b1);
endmodule

// File: rtl/seedwipe_seq.sv
// Top sequencer: key fetch, seed double-read, reseed, wipe and response.
// Assumes the handshake inputs are synchronous to clk. The disable input only has
// an effect until the final wipe entry has been taken.
module seedwipe_seq
    import seqw_pkg::*;
#(
    parameter int NSEEDS = 2,
    parameter int DW     = 32,
    parameter int NWIPE  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          init_i,
    input  logic                          disable_i,
    input  logic                          prov_en_i,
    input  logic [3:0]                    wipe_init_i,
    input  logic [3:0]                    wipe_key_i,
    input  logic [3:0]                    wipe_wait_i,
    output logic                          addr_key_req_o,
    input  logic                          addr_key_ack_i,
    output logic                          data_key_req_o,
    input  logic                          data_key_ack_i,
    output logic                          rd_req_o,
    output logic [$clog2(NSEEDS+1)-1:0]   rd_seed_idx_o,
    input  logic                          rd_done_i,
    input  logic                          rd_valid_i,
    input  logic [DW-1:0]                 rd_data_i,
    output logic [NSEEDS*DW-1:0]          seed_o,
    output logic                          reseed_req_o,
    input  logic                          reseed_ack_i,
    output logic                          wipe_go_o,
    output logic [$clog2(NWIPE)-1:0]      wipe_idx_o,
    input  logic                          wipe_done_i,
    input  logic                          eng_err_i,
    output logic                          wipe_done_o,
    output logic                          wipe_ok_o,
    output logic                          fatal_o
);
    seq_state_e st_q, nxt;
    logic [2:0] stg_on;
    logic       state_err, seed_err, seeds_done, wipe_last;
    logic       fsm_bad, fsm_err_q, eng_err_q, ok_q, wiped;

    wipe_req_decode #(.NSTAGE(3)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i ({wipe_wait_i, wipe_key_i, wipe_init_i}),
        .on_o  (stg_on),
        .err_o (state_err)
    );

    seed_reader #(.NSEEDS(NSEEDS), .DW(DW)) u_seed (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_req_o),
        .eval_en    (st_q == S_SEED_EVAL),
        .rd_valid   (rd_valid_i),
        .rd_data    (rd_data_i),
        .cnt_o      (rd_seed_idx_o),
        .all_done_o (seeds_done),
        .seeds_o    (seed_o),
        .err_o      (seed_err)
    );

    wipe_index #(.NWIPE(NWIPE)) u_widx (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (wipe_go_o && wipe_done_i),
        .idx_o  (wipe_idx_o),
        .last_o (wipe_last)
    );

    assign wiped = (st_q == S_WIPE_RSP) || (st_q == S_DEAD);

    // Next-state selection, with the disable override applied last.
    always_comb begin
        nxt     = st_q;
        fsm_bad = 1'b0;
        case (st_q)
            S_IDLE:      if (stg_on[0]) nxt = S_WIPE;
                         else if (init_i) nxt = S_ADDR_KEY;
            S_ADDR_KEY:  if (stg_on[1]) nxt = S_WIPE;
                         else if (addr_key_ack_i) nxt = S_DATA_KEY;
            S_DATA_KEY:  if (stg_on[1]) nxt = S_WIPE;
                         else if (data_key_ack_i) nxt = prov_en_i ? S_SEED_RD : S_HOLD;
            S_SEED_RD:   if (seeds_done) nxt = S_HOLD;
                         else if (rd_done_i) nxt = S_SEED_EVAL;
            S_SEED_EVAL: nxt = S_SEED_RD;
            S_HOLD:      if (stg_on[2]) nxt = S_RESEED;
            S_RESEED:    if (reseed_ack_i) nxt = S_WIPE;
            S_WIPE:      if (wipe_done_i && wipe_last) nxt = S_WIPE_RSP;
            S_WIPE_RSP:  nxt = S_DEAD;
            S_OFF:       nxt = S_OFF;
            S_DEAD:      nxt = S_DEAD;
            default: begin
                nxt     = S_DEAD;
                fsm_bad = 1'b1;
            end
        endcase
        if (disable_i && nxt != S_DEAD && !wiped) nxt = S_OFF;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= nxt;
    end

    // Sticky FSM and engine errors, and the result taken in the response cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_err_q <= 1'b0;
            eng_err_q <= 1'b0;
            ok_q      <= 1'b0;
        end else begin
            if (fsm_bad)   fsm_err_q <= 1'b1;
            if (eng_err_i) eng_err_q <= 1'b1;
            if (st_q == S_WIPE_RSP) ok_q <= !(seed_err || fatal_o);
        end
    end

    assign addr_key_req_o = (st_q == S_ADDR_KEY);
    assign data_key_req_o = (st_q == S_DATA_KEY);
    assign rd_req_o       = (st_q == S_SEED_RD) && !seeds_done;
    assign reseed_req_o   = (st_q == S_RESEED);
    assign wipe_go_o      = (st_q == S_WIPE);
    assign wipe_done_o    = (st_q == S_DEAD);
    assign wipe_ok_o      = (st_q == S_DEAD) && ok_q;
    assign fatal_o        = state_err || fsm_err_q || eng_err_q;

    // R10: disable before the response parks the sequencer with all requests low
    a_r10_disable_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (disable_i && !wiped) |=> !(addr_key_req_o || data_key_req_o || rd_req_o
                                    || reseed_req_o || wipe_go_o || wipe_done_o));
    // R9: the response is terminal
    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_done_o |=> wipe_done_o && $stable(wipe_ok_o));
    // R4: a key-stage wipe request pre-empts the key fetch
    a_r4_key_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr_key_req_o || data_key_req_o) && stg_on[1] && !disable_i) |=> wipe_go_o);
    // R2: the address key ack leads to the data key request
    a_r2_key_order: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_key_req_o && addr_key_ack_i && !stg_on[1] && !disable_i) |=> data_key_req_o);
    // R11: the fatal error never clears
    a_r11_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |=> fatal_o);
    // R2: at most one handshake request at a time
    a_r2_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_key_req_o, data_key_req_o, rd_req_o, reseed_req_o, wipe_go_o}));
endmodule

// File: tb/tb_seedwipe_seq.sv
module tb_seedwipe_seq;
    localparam int NSEEDS = 2;
    localparam int DW     = 32;
    localparam int NWIPE  = 3;
    localparam logic [3:0] ON  = 4'hA;
    localparam logic [3:0] OFF = 4'h5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_i = 0, disable_i = 0, prov_en_i = 0;
    logic [3:0] wipe_init_i = OFF, wipe_key_i = OFF, wipe_wait_i = OFF;
    logic addr_key_req_o, addr_key_ack_i = 0, data_key_req_o, data_key_ack_i = 0;
    logic rd_req_o, rd_done_i = 0, rd_valid_i = 0;
    logic [$clog2(NSEEDS+1)-1:0] rd_seed_idx_o;
    logic [DW-1:0] rd_data_i = '0;
    logic [NSEEDS*DW-1:0] seed_o;
    logic reseed_req_o, reseed_ack_i = 0, wipe_go_o, wipe_done_i = 0, eng_err_i = 0;
    logic [$clog2(NWIPE)-1:0] wipe_idx_o;
    logic wipe_done_o, wipe_ok_o, fatal_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    seedwipe_seq #(.NSEEDS(NSEEDS), .DW(DW), .NWIPE(NWIPE)) dut (.*);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic bit exp_ok(bit mism, bit bad, bit eng);
        return !(mism || bad || eng);
    endfunction

    function automatic logic [4:0] reqs();
        return {addr_key_req_o, data_key_req_o, rd_req_o, reseed_req_o, wipe_go_o};
    endfunction

    task automatic do_reset();
        rst_n = 0; init_i = 0; disable_i = 0; prov_en_i = 0;
        wipe_init_i = OFF; wipe_key_i = OFF; wipe_wait_i = OFF;
        addr_key_ack_i = 0; data_key_ack_i = 0; rd_done_i = 0; rd_valid_i = 0;
        reseed_ack_i = 0; wipe_done_i = 0; eng_err_i = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
    endtask

    // Wipe phase: we are in the wiping state at entry
    task automatic do_wipe(input bit exp_good);
        for (int w = 0; w < NWIPE; w++) begin
            chk(wipe_go_o && wipe_idx_o == w, "R8 wipe index", wipe_idx_o, w);
            repeat ($urandom_range(0, 2)) tick();
            wipe_done_i = 1; tick(); wipe_done_i = 0;
        end
        chk(!wipe_go_o && !wipe_done_o, "R8 wipe ends", {wipe_go_o, wipe_done_o}, 0);
        tick();
        chk(wipe_done_o == 1, "R9 response", wipe_done_o, 1);
        chk(wipe_ok_o == exp_good, "R9 result", wipe_ok_o, exp_good);
    endtask

    // Full flow from idle; mm = seed index whose second read mismatches, -1 none
    task automatic run_flow(input bit prov, input int mm, input bit bad, input bit eng);
        logic [DW-1:0] vals [NSEEDS];
        prov_en_i = prov;
        init_i = 1; tick(); init_i = 0;
        chk(addr_key_req_o == 1, "R1 init to addr key", addr_key_req_o, 1);
        repeat ($urandom_range(0, 3)) tick();
        chk(reqs() == 5'b10000, "R2 addr key holds", reqs(), 5'b10000);
        addr_key_ack_i = 1; tick(); addr_key_ack_i = 0;
        chk(reqs() == 5'b01000, "R2 data key", reqs(), 5'b01000);
        repeat ($urandom_range(0, 3)) tick();
        data_key_ack_i = 1; tick(); data_key_ack_i = 0;
        chk(rd_req_o == prov, "R2 provisioning select", rd_req_o, prov);
        if (prov) begin
            for (int s = 0; s < NSEEDS; s++) begin
                vals[s] = $urandom;
                for (int p = 0; p < 2; p++) begin
                    chk(rd_req_o && rd_seed_idx_o == s, "R5 read request", rd_seed_idx_o, s);
                    rd_valid_i = 1; rd_done_i = 1;
                    rd_data_i = (p == 1 && s == mm) ? (vals[s] ^ 32'h1) : vals[s];
                    tick();
                    rd_valid_i = 0; rd_done_i = 0; rd_data_i = $urandom;
                    chk(rd_req_o == 0, "R5 eval cycle", rd_req_o, 0);
                    tick();
                end
            end
            chk(rd_req_o == 0, "R5 all seeds read", rd_req_o, 0);
            for (int s = 0; s < NSEEDS; s++)
                chk(seed_o[s*DW +: DW] == vals[s], "R5 R6 stored seed", seed_o[s*DW +: DW], vals[s]);
            tick();
        end
        chk(reqs() == 0, "R2 wait state quiet", reqs(), 0);
        if (bad) begin
            wipe_wait_i = 4'h3; tick();
            chk(fatal_o && !reseed_req_o, "R3 bad code", {fatal_o, reseed_req_o}, 2'b10);
        end
        if (eng) begin
            eng_err_i = 1; tick(); eng_err_i = 0;
            chk(fatal_o == 1, "R11 engine error", fatal_o, 1);
        end
        wipe_wait_i = ON; tick(); wipe_wait_i = OFF;
        chk(reseed_req_o == 1, "R7 reseed request", reseed_req_o, 1);
        repeat ($urandom_range(0, 3)) tick();
        reseed_ack_i = 1; tick(); reseed_ack_i = 0;
        chk(wipe_go_o && wipe_idx_o == 0, "R7 wipe start", wipe_idx_o, 0);
        do_wipe(exp_ok(prov && mm >= 0, bad, eng));
        if (bad || eng) chk(fatal_o == 1, "R11 fatal held", fatal_o, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // R1 reset state
        chk(reqs() == 0 && !wipe_done_o && !wipe_ok_o && !fatal_o, "R1 reset",
            {reqs(), wipe_done_o, wipe_ok_o, fatal_o}, 0);

        run_flow(1, -1, 0, 0);
        // R10: disable after the response has no effect
        disable_i = 1; tick(); tick(); disable_i = 0;
        chk(wipe_done_o && wipe_ok_o, "R10 disable ignored after done", {wipe_done_o, wipe_ok_o}, 3);

        do_reset(); run_flow(0, -1, 0, 0);
        do_reset(); run_flow(1, 1, 0, 0);   // R6 mismatch on seed 1
        do_reset(); run_flow(1, 0, 0, 0);   // R6 mismatch on seed 0
        do_reset(); run_flow(0, -1, 1, 0);  // R3 malformed code
        do_reset(); run_flow(1, -1, 0, 1);  // R11 engine error

        // R4: wipe at init stage
        do_reset();
        wipe_init_i = ON; tick(); wipe_init_i = OFF;
        chk(wipe_go_o && wipe_idx_o == 0, "R4 init preempt", reqs(), 5'b00001);
        do_wipe(1);

        // R4: wipe at key stage, during the data key request
        do_reset();
        init_i = 1; tick(); init_i = 0;
        addr_key_ack_i = 1; tick(); addr_key_ack_i = 0;
        wipe_key_i = ON; tick(); wipe_key_i = OFF;
        chk(reqs() == 5'b00001, "R4 key preempt", reqs(), 5'b00001);
        do_wipe(1);

        // R4: key stage during the address key request
        do_reset();
        init_i = 1; tick(); init_i = 0;
        wipe_key_i = ON; tick(); wipe_key_i = OFF;
        chk(reqs() == 5'b00001, "R4 key preempt addr", reqs(), 5'b00001);
        do_wipe(1);

        // R10: disable in the middle of the wipe
        do_reset();
        wipe_init_i = ON; tick(); wipe_init_i = OFF;
        wipe_done_i = 1; tick(); wipe_done_i = 0;
        disable_i = 1; tick(); disable_i = 0;
        chk(reqs() == 0 && !wipe_done_o, "R10 disable mid wipe", reqs(), 0);
        init_i = 1; wipe_init_i = ON; wipe_done_i = 1; tick(); tick();
        init_i = 0; wipe_init_i = OFF; wipe_done_i = 0;
        chk(reqs() == 0 && !wipe_done_o, "R10 disabled terminal", reqs(), 0);

        // R10: disable while waiting for a key ack
        do_reset();
        init_i = 1; tick(); init_i = 0;
        disable_i = 1; addr_key_ack_i = 1; tick(); disable_i = 0; addr_key_ack_i = 0;
        chk(reqs() == 0, "R10 disable in key fetch", reqs(), 0);

        // Random runs
        for (int i = 0; i < 8; i++) begin
            bit p;
            int m;
            p = 1'($urandom_range(0, 1));
            m = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, NSEEDS - 1)) : -1;
            do_reset();
            run_flow(p, m, 0, 0);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule